// File: doc/BRIEF.md
# Page-Wrapping Word Address Counter

This block holds the word address of a paged serial memory. A protocol front end loads it from two serial bytes, the upper byte first and the lower byte second. It then steps the address once for each data byte that is transferred. The counter supports two stepping modes. When a write burst is stored, only the offset within the current page advances, so a burst longer than one page comes back to the start of the same page and overwrites what was written there earlier. When data is read out, the whole address advances and runs through the full array, going back to zero after the top location.

The counter keeps its value while no transfer is in progress. After any access it therefore points one past the last byte touched, which is what a current-address read uses. The address width is a parameter: 12 bits gives 4096 bytes and 13 bits gives 8192 bytes. The page size is also a parameter and defaults to 32 bytes, which gives 128 or 256 pages.

Top module: `word_addr_counter`

## Requirements
- R1: While `rstN` is low at a rising clock edge, `addr` becomes 0 at that edge.
- R2: `loadHi` stores `dataIn[ADDR_W-9:0]` into `addr[ADDR_W-1:8]` at the edge and leaves `addr[7:0]` unchanged.
- R3: On `loadHi`, the bits `dataIn[7:ADDR_W-8]` have no effect on `addr`.
- R4: `loadLo` alone stores `dataIn` into `addr[7:0]` and leaves the upper address bits unchanged.
- R5: With `incr` high and `writeMode` high (store mode), only the page offset `addr[log2(PAGE_BYTES)-1:0]` increments, modulo PAGE_BYTES. The page bits are unchanged, so the step after offset PAGE_BYTES-1 gives offset 0 of the same page.
- R6: With `incr` high and `writeMode` low (read mode), `addr` increments modulo 2^ADDR_W, so the step after the top address gives 0.
- R7: With no `loadHi`, `loadLo` or `incr`, `addr` keeps its value, so it still holds the last accessed address plus one.
- R8: Priority is fixed. `loadHi` wins over `loadLo`, and either load wins over `incr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| loadHi | input | 1 | Load the upper address byte from dataIn |
| loadLo | input | 1 | Load the lower address byte from dataIn |
| dataIn | input | 8 | Address byte received from the bus |
| incr | input | 1 | Advance the address by one byte |
| writeMode | input | 1 | 1: step wraps inside the page; 0: step wraps across the array |
| addr | output | ADDR_W | Current word address |

## Verification
The bound checker evaluates the single-cycle relations on every clock:
- an idle cycle holds the address;
- a store-mode step keeps the page bits and advances the offset by one;
- a read-mode step adds one across the full width;
- each load changes only its own byte.

Some behaviours only the bench scenarios can show, because they need a chosen sequence of stimulus:
- a burst longer than a page coming back over the same page;
- the read counter passing from the top address to zero;
- the reset value;
- the priority between strobes that arrive together.

// File: rtl/wac_pkg.sv
`timescale 1ns/1ps
package wac_pkg;
  // Strobes decoded by the control and consumed by the datapath; at most one is high.
  typedef struct packed {
    logic takeHi;
    logic takeLo;
    logic stepPage;
    logic stepFull;
  } wacStrobes_t;
endpackage

// File: rtl/wac_ctrl.sv
`timescale 1ns/1ps
module wac_ctrl
  import wac_pkg::*;
(
  input  logic        loadHi,
  input  logic        loadLo,
  input  logic        incr,
  input  logic        writeMode,
  output wacStrobes_t strobes
);
  // Fixed priority: upper load, lower load, then a step of the selected kind.
  always_comb begin
    strobes = '0;
    if (loadHi)          strobes.takeHi   = 1'b1;
    else if (loadLo)     strobes.takeLo   = 1'b1;
    else if (incr) begin
      if (writeMode)     strobes.stepPage = 1'b1;
      else               strobes.stepFull = 1'b1;
    end
  end
endmodule

// File: rtl/wac_datapath.sv
`timescale 1ns/1ps
module wac_datapath
  import wac_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int PAGE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  wacStrobes_t       strobes,
  input  logic [7:0]        dataIn,
  output logic [ADDR_W-1:0] addrQ
);
  localparam int HI_W  = ADDR_W - 8;
  localparam int OFS_W = $clog2(PAGE_BYTES);
  localparam logic [OFS_W-1:0]  OFS_ONE  = 1;
  localparam logic [ADDR_W-1:0] ADDR_ONE = 1;

  logic [ADDR_W-1:0] nextAddr;
  logic [OFS_W-1:0]  nextOfs;

  // Bits of the upper byte that lie above the address width are dropped.
  logic unusedHiBits;
  assign unusedHiBits = ^dataIn[7:HI_W];

  assign nextOfs = addrQ[OFS_W-1:0] + OFS_ONE;

  always_comb begin
    nextAddr = addrQ;
    if (strobes.takeHi)        nextAddr[ADDR_W-1:8] = dataIn[HI_W-1:0];
    else if (strobes.takeLo)   nextAddr[7:0]        = dataIn;
    else if (strobes.stepPage) nextAddr[OFS_W-1:0]  = nextOfs;
    else if (strobes.stepFull) nextAddr             = addrQ + ADDR_ONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) addrQ <= '0;
    else       addrQ <= nextAddr;
  end
endmodule

// File: rtl/word_addr_counter.sv
`timescale 1ns/1ps
module word_addr_counter
  import wac_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int PAGE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadHi,
  input  logic              loadLo,
  input  logic [7:0]        dataIn,
  input  logic              incr,
  input  logic              writeMode,
  output logic [ADDR_W-1:0] addr
);
  wacStrobes_t strobes;

  wac_ctrl ctrl_i (
    .loadHi    (loadHi),
    .loadLo    (loadLo),
    .incr      (incr),
    .writeMode (writeMode),
    .strobes   (strobes)
  );

  wac_datapath #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .dataIn  (dataIn),
    .addrQ   (addr)
  );
endmodule

// File: rtl/wac_checker.sv
`timescale 1ns/1ps
module wac_checker #(
  parameter int ADDR_W     = 13,
  parameter int PAGE_BYTES = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              loadHi,
  input logic              loadLo,
  input logic [7:0]        dataIn,
  input logic              incr,
  input logic              writeMode,
  input logic [ADDR_W-1:0] addr
);
  localparam int HI_W  = ADDR_W - 8;
  localparam int OFS_W = $clog2(PAGE_BYTES);

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!loadHi && !loadLo && !incr) |=> $stable(addr)); // R7

  AST_PAGE_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (!loadHi && !loadLo && incr && writeMode) |=> addr[ADDR_W-1:OFS_W] == $past(addr[ADDR_W-1:OFS_W])); // R5

  AST_OFFSET_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!loadHi && !loadLo && incr && writeMode) |=> addr[OFS_W-1:0] == $past(addr[OFS_W-1:0]) + 1'b1); // R5

  AST_FULL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!loadHi && !loadLo && incr && !writeMode) |=> addr == $past(addr) + 1'b1); // R6

  AST_HI_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    loadHi |=> (addr[ADDR_W-1:8] == $past(dataIn[HI_W-1:0])) && (addr[7:0] == $past(addr[7:0]))); // R2

  AST_LO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (loadLo && !loadHi) |=> (addr[7:0] == $past(dataIn)) && (addr[ADDR_W-1:8] == $past(addr[ADDR_W-1:8]))); // R4
endmodule

bind word_addr_counter wac_checker #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) chk_i (
  .clk(clk), .rstN(rstN), .loadHi(loadHi), .loadLo(loadLo),
  .dataIn(dataIn), .incr(incr), .writeMode(writeMode), .addr(addr)
);

// File: tb/word_addr_counter_tb_top.sv
`timescale 1ns/1ps
module word_addr_counter_tb_top;
  localparam int ADDR_W     = 13;
  localparam int PAGE_BYTES = 32;
  localparam int SPAN       = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic loadHi = 1'b0, loadLo = 1'b0, incr = 1'b0, writeMode = 1'b0;
  logic [7:0] dataIn = 8'h00;
  logic [ADDR_W-1:0] addr;

  int nChecks = 0;
  int nFails  = 0;
  int model   = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  word_addr_counter #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) dut_i (
    .clk(clk), .rstN(rstN), .loadHi(loadHi), .loadLo(loadLo),
    .dataIn(dataIn), .incr(incr), .writeMode(writeMode), .addr(addr)
  );

  // Behavioural reference, written from the requirements.
  function automatic int refNext(int cur, bit r, bit lh, bit ll, bit inc, bit wm, int d);
    int hiMask;
    hiMask = (1 << (ADDR_W - 8)) - 1;
    if (!r)       return 0;
    if (lh)       return (cur % 256) + ((d & hiMask) * 256);
    if (ll)       return (cur - (cur % 256)) + d;
    if (inc && wm) return (cur - (cur % PAGE_BYTES)) + ((cur + 1) % PAGE_BYTES);
    if (inc)      return (cur + 1) % SPAN;
    return cur;
  endfunction

  // Drive one cycle at the falling edge, update the model at the rising edge,
  // compare at the next falling edge.
  task automatic cyc(string tag, bit r, bit lh, bit ll, bit inc, bit wm, int d);
    rstN = r; loadHi = lh; loadLo = ll; incr = inc; writeMode = wm; dataIn = d[7:0];
    @(posedge clk);
    model = refNext(model, r, lh, ll, inc, wm, d);
    @(negedge clk);
    nChecks++;
    if (int'(addr) != model) begin
      nFails++;
      $display("FAIL %s addr=0x%0h expected=0x%0h", tag, addr, model);
    end
  endtask

  initial begin
    @(negedge clk);
    cyc("R1", 0, 0, 0, 0, 0, 0);
    cyc("R1", 0, 1, 1, 1, 0, 8'h55);
    // upper byte with junk bits above the width (R3), then lower byte
    cyc("R3", 1, 1, 0, 0, 0, 8'hFA);
    cyc("R4", 1, 0, 1, 0, 0, 8'h3C);
    cyc("R2", 1, 1, 0, 0, 0, 8'h07);
    // idle holds (R7)
    for (int i = 0; i < 3; i++) cyc("R7", 1, 0, 0, 0, 1, 8'hFF);
    // store-mode burst of 40 bytes wraps in the page (R5)
    for (int i = 0; i < 40; i++) cyc("R5", 1, 0, 0, 1, 1, 0);
    cyc("R7", 1, 0, 0, 0, 0, 0);
    // read mode passes through a page boundary and the array top (R6)
    cyc("R2", 1, 1, 0, 0, 0, 8'h1F);
    cyc("R4", 1, 0, 1, 0, 0, 8'hFC);
    for (int i = 0; i < 8; i++) cyc("R6", 1, 0, 0, 1, 0, 0);
    cyc("R4", 1, 0, 1, 0, 0, 8'h1E);
    for (int i = 0; i < 4; i++) cyc("R6", 1, 0, 0, 1, 0, 0);
    // store mode at offset 31 of the last page
    cyc("R2", 1, 1, 0, 0, 0, 8'h1F);
    cyc("R4", 1, 0, 1, 0, 0, 8'hFF);
    cyc("R5", 1, 0, 0, 1, 1, 0);
    // priority (R8)
    cyc("R8", 1, 1, 1, 1, 0, 8'h0A);
    cyc("R8", 1, 0, 1, 1, 1, 8'h9D);
    cyc("R8", 1, 1, 0, 1, 1, 8'h03);
    // reset in the middle of traffic (R1)
    cyc("R1", 0, 0, 0, 1, 0, 0);
    cyc("R7", 1, 0, 0, 0, 0, 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule